// File: doc/BRIEF.md
# Single-Cycle RISC Subset Core

This block is a single-cycle execution core for a small 32-bit, three-operand, load/store instruction subset. It fetches one 32-bit word per cycle from an internal instruction store and decodes it as either a register-format or an immediate-format word. It reads two registers from a 32 x 32-bit register file and computes a result. It then writes back, loads or stores against a small internal word-addressed data memory, and moves the program counter to the next instruction, a branch target or a jump target, all on one clock edge.

Programs are written into the instruction store through a plain write port. Execution advances only while `run` is high. Two combinational peek ports expose one register and one data-memory word, so the state can be checked after a program finishes. Words whose opcode or function code is not in the subset leave all state alone and only advance the PC.

Top module: `risc_core`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) sets the PC to 0, clears every register and clears every data-memory word.
- R2: While `run` is low, the PC, registers and data memory hold their values. The instruction store accepts `prog_we` writes at any time, including during reset.
- R3: A word with opcode bits [31:26] = 0 is register-format, with rs=[25:21], rt=[20:16], rd=[15:11], shamt=[10:6] and funct=[5:0]. funct 32 writes rs+rt to rd and funct 34 writes rs-rt to rd (32'h02324020 adds r17 and r18 into r8).
- R4: funct 36, 37 and 39 write rs AND rt, rs OR rt and NOT(rs OR rt) to rd. NOR with register 0 as rt gives the bitwise NOT of rs.
- R5: funct 0 and funct 2 shift rt left or right, logically, by shamt positions, filling with zeros, and write the result to rd.
- R6: funct 42 writes 1 to rd when rs < rt as signed values, and 0 otherwise. Opcode 10 writes the same kind of flag to rt, comparing rs with the sign-extended 16-bit constant in [15:0].
- R7: Opcode 8 writes rs plus the sign-extended constant to rt. Opcodes 12 and 13 write rs AND, or rs OR, the zero-extended constant to rt.
- R8: Register 0 always reads as zero, and writes aimed at it are dropped.
- R9: Opcode 35 loads and opcode 43 stores one word at address rs + sign-extended offset. Data-memory words are selected by address bits [DMEM_AW+1:2]. A load writes rt and a store takes its data from rt.
- R10: Opcode 4 branches when rs == rt and opcode 5 branches when rs != rt. The target is PC+4 plus the sign-extended offset shifted left by 2. When the condition fails, the PC becomes PC+4.
- R11: Opcode 2 always jumps to {PC+4 bits [31:28], word bits [25:0], 2'b00}.
- R12: An opcode outside the listed set, or an opcode-0 word with an unlisted funct, changes no register or memory word, and the PC becomes PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High to execute one instruction per cycle |
| prog_we | input | 1 | Instruction store write strobe |
| prog_addr | input | IMEM_AW | Instruction store word index |
| prog_data | input | 32 | Instruction word to store |
| pc_o | output | 32 | Current program counter |
| peek_reg_sel | input | 5 | Register number to observe |
| peek_reg_val | output | 32 | Value of the selected register |
| peek_mem_sel | input | DMEM_AW | Data-memory word index to observe |
| peek_mem_val | output | 32 | Value of the selected data-memory word |

## Verification
The bench targets the extension rules: a negative constant given to andi or ori must come out zero-extended, while the same constant given to addi or slti must be sign-extended. A core that swaps the two turns 0x8000 into 0xFFFF8000 where it should not, or the reverse. Set-less-than is run on mixed-sign operands, so an unsigned comparator reports -3 < 5 as false. A shift of 31 and a shift of a negative value show whether zeros are shifted in and whether rt, not rs, is the operand. Branches are tested both taken and not taken, and with a negative offset, which exposes a missing sign extension or a target computed from PC instead of PC+4. Writes to register 0 and undefined words are checked at the peek ports, which catches a core that lets them corrupt state.

// File: rtl/risc_pkg.sv
// Shared encodings and control types for the single-cycle core.
package risc_pkg;
    localparam int XLEN = 32;

    // Primary opcodes, bits [31:26]
    localparam logic [5:0] OP_REG  = 6'd0;
    localparam logic [5:0] OP_J    = 6'd2;
    localparam logic [5:0] OP_BEQ  = 6'd4;
    localparam logic [5:0] OP_BNE  = 6'd5;
    localparam logic [5:0] OP_ADDI = 6'd8;
    localparam logic [5:0] OP_SLTI = 6'd10;
    localparam logic [5:0] OP_ANDI = 6'd12;
    localparam logic [5:0] OP_ORI  = 6'd13;
    localparam logic [5:0] OP_LW   = 6'd35;
    localparam logic [5:0] OP_SW   = 6'd43;

    // Function codes for register-format words, bits [5:0]
    localparam logic [5:0] FN_SLL = 6'd0;
    localparam logic [5:0] FN_SRL = 6'd2;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_NOR = 6'd39;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT, ALU_SLL, ALU_SRL
    } alu_op_e;

    typedef struct packed {
        logic    reg_write;  // result goes to the register file
        logic    dst_is_rd;  // destination is rd (else rt)
        logic    use_imm;    // second operand is the extended constant
        logic    imm_zext;   // zero-extend the constant (else sign-extend)
        alu_op_e alu_op;
        logic    mem_read;
        logic    mem_write;
        logic    br_eq;
        logic    br_ne;
        logic    jump;
    } ctrl_t;
endpackage

// File: rtl/risc_decoder.sv
// Instruction decoder.
// Turns one instruction word into control signals. Assumes the fixed
// 6/5/5/5/5/6 and 6/5/5/16 layouts. Any word outside the subset decodes
// to an all-zero control word, so it leaves state alone and the PC steps by 4.
module risc_decoder
    import risc_pkg::*;
(
    input  logic [31:0] instr,
    output ctrl_t       ctl
);
    logic [5:0] opcode;
    logic [5:0] funct;

    assign opcode = instr[31:26];
    assign funct  = instr[5:0];

    // Map opcode and funct onto the control word.
    always_comb begin
        ctl = '0;
        ctl.alu_op = ALU_ADD;
        unique case (opcode)
            OP_REG: begin
                ctl.reg_write = 1'b1;
                ctl.dst_is_rd = 1'b1;
                case (funct)
                    FN_ADD:  ctl.alu_op = ALU_ADD;
                    FN_SUB:  ctl.alu_op = ALU_SUB;
                    FN_AND:  ctl.alu_op = ALU_AND;
                    FN_OR:   ctl.alu_op = ALU_OR;
                    FN_NOR:  ctl.alu_op = ALU_NOR;
                    FN_SLT:  ctl.alu_op = ALU_SLT;
                    FN_SLL:  ctl.alu_op = ALU_SLL;
                    FN_SRL:  ctl.alu_op = ALU_SRL;
                    default: ctl.reg_write = 1'b0;
                endcase
            end
            OP_ADDI: begin
                ctl.reg_write = 1'b1;
                ctl.use_imm   = 1'b1;
            end
            OP_SLTI: begin
                ctl.reg_write = 1'b1;
                ctl.use_imm   = 1'b1;
                ctl.alu_op    = ALU_SLT;
            end
            OP_ANDI: begin
                ctl.reg_write = 1'b1;
                ctl.use_imm   = 1'b1;
                ctl.imm_zext  = 1'b1;
                ctl.alu_op    = ALU_AND;
            end
            OP_ORI: begin
                ctl.reg_write = 1'b1;
                ctl.use_imm   = 1'b1;
                ctl.imm_zext  = 1'b1;
                ctl.alu_op    = ALU_OR;
            end
            OP_LW: begin
                ctl.reg_write = 1'b1;
                ctl.use_imm   = 1'b1;
                ctl.mem_read  = 1'b1;
            end
            OP_SW: begin
                ctl.use_imm   = 1'b1;
                ctl.mem_write = 1'b1;
            end
            OP_BEQ:  ctl.br_eq = 1'b1;
            OP_BNE:  ctl.br_ne = 1'b1;
            OP_J:    ctl.jump  = 1'b1;
            default: ctl = '0;
        endcase
    end

    // A store never also writes a register, and control transfers never write state.
    // R12
    always_comb begin
        store_no_wb_chk: assert (!(ctl.mem_write && ctl.reg_write));
    end
endmodule

// File: rtl/risc_alu.sv
// Combinational ALU.
// Add, subtract, three bitwise ops, signed set-less-than and logical
// shifts. Assumes the shift count comes from the shamt field and the
// shifted operand arrives on b (the rt value).
module risc_alu
    import risc_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [4:0]     shamt,
    output logic [W-1:0]   y
);
    // Select the operation result.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOR: y = ~(a | b);
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLL: y = b << shamt;
            ALU_SRL: y = b >> shamt;
            default: y = '0;
        endcase
    end

    // A set-less-than result is only ever 0 or 1.
    // R6
    always_comb begin
        if (op == ALU_SLT) slt_flag_width_chk: assert (y[W-1:1] == '0);
    end
endmodule

// File: rtl/risc_regfile.sv
// Register file: N entries of W bits, two read ports, one write port and
// one observation port. Entry 0 has no storage and reads as zero.
// Assumes a synchronous active-low reset that clears every entry.
module risc_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_peek,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_peek,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);
    logic [W-1:0] regs [N];

    // Clear on reset; otherwise write any entry but 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Read ports; entry 0 is forced to zero.
    always_comb begin
        rd_a    = (ra_a == '0)    ? '0 : regs[ra_a];
        rd_b    = (ra_b == '0)    ? '0 : regs[ra_b];
        rd_peek = (ra_peek == '0) ? '0 : regs[ra_peek];
    end

    // A write to a nonzero entry is visible on the observation port next cycle.
    // R8
    wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa != '0 && ra_peek == wa) ##1 (ra_peek == $past(wa)) |-> (rd_peek == $past(wd)));

    // Entry 0 stays zero whatever was written to it.
    // R8
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == '0 && ra_peek == '0) |=> (ra_peek != '0) || (rd_peek == '0));
endmodule

// File: rtl/risc_core.sv
// Single-cycle core top.
// Fetch, decode, execute, memory access and write-back all complete on one
// clock edge while run is high. Assumes the program is written through the
// prog_* port before run is raised; the instruction store is not cleared by
// reset, the PC, registers and data memory are.
module risc_core
    import risc_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               prog_we,
    input  logic [IMEM_AW-1:0] prog_addr,
    input  logic [31:0]        prog_data,
    output logic [31:0]        pc_o,
    input  logic [4:0]         peek_reg_sel,
    output logic [31:0]        peek_reg_val,
    input  logic [DMEM_AW-1:0] peek_mem_sel,
    output logic [31:0]        peek_mem_val
);
    localparam int IMEM_WORDS = 1 << IMEM_AW;
    localparam int DMEM_WORDS = 1 << DMEM_AW;

    logic [31:0] imem [IMEM_WORDS];
    logic [31:0] dmem [DMEM_WORDS];
    logic [31:0] pc_q;
    logic [31:0] instr;
    ctrl_t       ctl;

    logic [4:0]  f_rs, f_rt, f_rd, f_shamt;
    logic [15:0] f_imm;
    logic [31:0] imm_sext, imm_ext;
    logic [31:0] rs_val, rt_val, alu_b, alu_y, wb_data;
    logic [4:0]  wb_addr;
    logic [DMEM_AW-1:0] dm_idx;
    logic [31:0] pc_plus4, br_target, j_target, next_pc;
    logic        ops_equal, take_br;

    // Program load port into the instruction store.
    always_ff @(posedge clk) begin
        if (prog_we) imem[prog_addr] <= prog_data;
    end

    assign instr   = imem[pc_q[IMEM_AW+1:2]];
    assign f_rs    = instr[25:21];
    assign f_rt    = instr[20:16];
    assign f_rd    = instr[15:11];
    assign f_shamt = instr[10:6];
    assign f_imm   = instr[15:0];

    risc_decoder u_dec (
        .instr (instr),
        .ctl   (ctl)
    );

    risc_regfile #(.W(XLEN), .N(32)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_a    (f_rs),
        .ra_b    (f_rt),
        .ra_peek (peek_reg_sel),
        .rd_a    (rs_val),
        .rd_b    (rt_val),
        .rd_peek (peek_reg_val),
        .we      (run && ctl.reg_write),
        .wa      (wb_addr),
        .wd      (wb_data)
    );

    // Operand selection and constant extension.
    always_comb begin
        imm_sext = {{16{f_imm[15]}}, f_imm};
        imm_ext  = ctl.imm_zext ? {16'b0, f_imm} : imm_sext;
        alu_b    = ctl.use_imm ? imm_ext : rt_val;
        wb_addr  = ctl.dst_is_rd ? f_rd : f_rt;
    end

    risc_alu #(.W(XLEN)) u_alu (
        .op    (ctl.alu_op),
        .a     (rs_val),
        .b     (alu_b),
        .shamt (f_shamt),
        .y     (alu_y)
    );

    assign dm_idx  = alu_y[DMEM_AW+1:2];
    assign wb_data = ctl.mem_read ? dmem[dm_idx] : alu_y;

    // Data memory: cleared on reset, written by stores while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DMEM_WORDS; i++) dmem[i] <= '0;
        end else if (run && ctl.mem_write) begin
            dmem[dm_idx] <= rt_val;
        end
    end

    assign peek_mem_val = dmem[peek_mem_sel];

    // Next-PC selection: sequential, branch or jump.
    always_comb begin
        pc_plus4  = pc_q + 32'd4;
        br_target = pc_plus4 + {imm_sext[29:0], 2'b00};
        j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
        ops_equal = (rs_val == rt_val);
        take_br   = (ctl.br_eq && ops_equal) || (ctl.br_ne && !ops_equal);
        if (ctl.jump)      next_pc = j_target;
        else if (take_br)  next_pc = br_target;
        else               next_pc = pc_plus4;
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)   pc_q <= '0;
        else if (run) pc_q <= next_pc;
    end

    assign pc_o = pc_q;

    // R2
    hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(pc_q));

    // R10
    branch_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && take_br && !ctl.jump) |=> (pc_q == $past(br_target)));

    // R10
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !take_br && !ctl.jump) |=> (pc_q == $past(pc_q) + 32'd4));

    // R11
    jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctl.jump) |=> (pc_q[27:2] == $past(instr[25:0])));

    // R9
    store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctl.mem_write) |=> (dmem[$past(dm_idx)] == $past(rt_val)));

    // R10
    pc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[1:0] == 2'b00);
endmodule

// File: tb/tb_risc_core.sv
// Directed bench: each task loads a program, runs it and checks state via the peek ports.
module tb_risc_core;
    localparam int IMEM_AW = 6;
    localparam int DMEM_AW = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               run = 1'b0;
    logic               prog_we = 1'b0;
    logic [IMEM_AW-1:0] prog_addr = '0;
    logic [31:0]        prog_data = '0;
    logic [31:0]        pc_o;
    logic [4:0]         peek_reg_sel = '0;
    logic [31:0]        peek_reg_val;
    logic [DMEM_AW-1:0] peek_mem_sel = '0;
    logic [31:0]        peek_mem_val;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    risc_core #(.IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) dut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
        .pc_o(pc_o),
        .peek_reg_sel(peek_reg_sel), .peek_reg_val(peek_reg_val),
        .peek_mem_sel(peek_mem_sel), .peek_mem_val(peek_mem_val)
    );

    function automatic logic [31:0] rw(int rs, int rt, int rd, int sh, int fn);
        return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
    endfunction
    function automatic logic [31:0] iw(int op, int rs, int rt, int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] jw(int idx);
        return {6'd2, idx[25:0]};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(string tag, int r, logic [31:0] exp);
        peek_reg_sel = r[4:0];
        #1;
        check(tag, peek_reg_val, exp);
    endtask

    task automatic chk_mem(string tag, int w, logic [31:0] exp);
        peek_mem_sel = w[DMEM_AW-1:0];
        #1;
        check(tag, peek_mem_val, exp);
    endtask

    task automatic put(int a, logic [31:0] w);
        prog_we = 1'b1; prog_addr = a[IMEM_AW-1:0]; prog_data = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic enter_reset();
        run = 1'b0; rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    // Release reset, hold with run low, then run n cycles and stop.
    task automatic go(int n);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 pc held while run low", pc_o, 32'd0);
        run = 1'b1;
        repeat (n) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        enter_reset();
        put(0, jw(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pc after reset", pc_o, 32'd0);
        chk_reg("R1 r5 after reset", 5, 32'd0);
        chk_reg("R1 r31 after reset", 31, 32'd0);
        chk_mem("R1 mem0 after reset", 0, 32'd0);
        chk_mem("R1 mem31 after reset", 31, 32'd0);
    endtask

    task automatic t_alu();
        enter_reset();
        put(0,  iw(8, 0, 17, 5));
        put(1,  iw(8, 0, 18, -3));
        put(2,  32'h02324020);          // add r8, r17, r18
        put(3,  rw(17, 18, 9, 0, 34));
        put(4,  iw(13, 0, 10, 'h0DC0));
        put(5,  iw(13, 0, 11, 'h3C00));
        put(6,  rw(10, 11, 12, 0, 36));
        put(7,  rw(10, 11, 13, 0, 37));
        put(8,  rw(11, 0, 14, 0, 39));
        put(9,  iw(12, 18, 15, 'hFFFF));
        put(10, iw(13, 0, 16, 'h8000));
        put(11, iw(8, 0, 19, 'h8000));
        put(12, rw(0, 17, 20, 4, 0));
        put(13, rw(0, 18, 21, 28, 2));
        put(14, rw(0, 18, 22, 31, 0));
        put(15, rw(18, 17, 23, 0, 42));
        put(16, rw(17, 18, 24, 0, 42));
        put(17, iw(10, 18, 25, -2));
        put(18, iw(10, 17, 26, 5));
        put(19, iw(8, 0, 0, 7));
        put(20, rw(0, 0, 27, 0, 32));
        put(21, iw(63, 0, 28, 5));      // undefined opcode
        put(22, rw(17, 17, 29, 0, 63)); // undefined funct
        put(23, jw(23));
        go(40);
        chk_reg("R3 add", 8, 32'd2);
        chk_reg("R3 sub", 9, 32'd8);
        chk_reg("R4 and", 12, 32'h0000_0C00);
        chk_reg("R4 or", 13, 32'h0000_3DC0);
        chk_reg("R4 nor as not", 14, 32'hFFFF_C3FF);
        chk_reg("R7 andi zero-extends", 15, 32'h0000_FFFD);
        chk_reg("R7 ori zero-extends", 16, 32'h0000_8000);
        chk_reg("R7 addi sign-extends", 19, 32'hFFFF_8000);
        chk_reg("R5 sll", 20, 32'd80);
        chk_reg("R5 srl zero fill", 21, 32'h0000_000F);
        chk_reg("R5 sll by 31", 22, 32'h8000_0000);
        chk_reg("R6 slt signed true", 23, 32'd1);
        chk_reg("R6 slt signed false", 24, 32'd0);
        chk_reg("R6 slti negative const", 25, 32'd1);
        chk_reg("R6 slti equal", 26, 32'd0);
        chk_reg("R8 r0 write ignored", 0, 32'd0);
        chk_reg("R8 r0 reads zero", 27, 32'd0);
        chk_reg("R12 undefined opcode", 28, 32'd0);
        chk_reg("R12 undefined funct", 29, 32'd0);
        check("R11 jump self loop", pc_o, 32'd92);
    endtask

    task automatic t_mem();
        enter_reset();
        put(0, iw(8, 0, 1, 8));
        put(1, iw(8, 0, 2, 'h123));
        put(2, iw(43, 1, 2, 4));
        put(3, iw(43, 1, 1, -4));
        put(4, iw(35, 1, 3, 4));
        put(5, iw(35, 1, 4, -4));
        put(6, iw(35, 0, 5, 0));
        put(7, jw(7));
        go(20);
        chk_mem("R9 store positive offset", 3, 32'h123);
        chk_mem("R9 store negative offset", 1, 32'd8);
        chk_mem("R9 untouched word", 2, 32'd0);
        chk_reg("R9 load positive offset", 3, 32'h123);
        chk_reg("R9 load negative offset", 4, 32'd8);
        chk_reg("R9 load zero word", 5, 32'd0);
    endtask

    task automatic t_branch();
        enter_reset();
        put(0,  iw(8, 0, 1, 1));
        put(1,  iw(8, 0, 2, 1));
        put(2,  iw(4, 1, 2, 2));        // taken, to word 5
        put(3,  iw(8, 0, 3, 99));
        put(4,  iw(8, 0, 4, 99));
        put(5,  iw(5, 1, 2, 5));        // not taken
        put(6,  iw(8, 0, 5, 7));
        put(7,  iw(5, 1, 0, 1));        // taken, to word 9
        put(8,  iw(8, 0, 6, 99));
        put(9,  iw(4, 1, 0, 1));        // not taken
        put(10, iw(8, 0, 7, 3));
        put(11, jw(14));
        put(12, iw(8, 0, 8, 99));
        put(13, iw(8, 0, 8, 99));
        put(14, iw(4, 0, 0, -1));       // self loop via negative offset
        go(30);
        chk_reg("R10 beq taken skips", 3, 32'd0);
        chk_reg("R10 beq taken skips second", 4, 32'd0);
        chk_reg("R10 bne not taken falls through", 5, 32'd7);
        chk_reg("R10 bne taken skips", 6, 32'd0);
        chk_reg("R10 beq not taken falls through", 7, 32'd3);
        chk_reg("R11 jump skips", 8, 32'd0);
        check("R10 negative offset loop", pc_o, 32'd56);
        repeat (3) @(negedge clk);
        check("R2 pc holds after stop", pc_o, 32'd56);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_alu();
        t_mem();
        t_branch();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule